// File: doc/BRIEF.md
# Single-Bit Register and Memory Operation Unit

This unit carries out one-bit edits on a 32-bit operand: clear a bit, set a bit, flip a bit, or inspect a bit and report the result as a zero flag. The operand is either one of 16 architectural registers or one 16-bit word in memory. The opcode family (clear family or set family) and an alternate-operation bit from the opcode extension choose the operation. The bit index is built from a 2-bit group number, which tells which of four legacy opcodes was used, and a 3-bit field from the extension.

In register mode the surrounding register file supplies the selected register's value on `reg_rdata`. The unit returns the edited value with a write-enable, or a zero-flag update for the inspect operation, one cycle after the request. In memory mode the selected register is a base pointer. The unit adds a zero-extended 16-bit offset to it, and the status register reads as zero when used as a base. It then runs a read, modify and write-back sequence over a simple word port with one cycle of read latency.

Top module: `bitop_unit`

## Requirements
- R1: The operation code is {alt, fam_set}: 00 clears the bit, 01 sets it, 11 inverts it, 10 inspects it. In register mode `wb_data` is `reg_rdata` with only the selected bit changed, and `wb_sel` repeats `reg_sel`.
- R2: The bit index is {grp, ext_bit}, with grp in bits 4:3 and ext_bit in bits 2:0. It selects bit 0 to 31 of a register operand.
- R3: A register-mode request accepted at a clock edge shows `done` in the next cycle, together with `wb_we` for clear, set and invert. A new request is accepted in the cycle that shows `done`.
- R4: The inspect operation never asserts `wb_we` or `mem_we`. With `done` it asserts `z_we`, and `z_val` is 1 when the selected bit is 0 and 0 when it is 1.
- R5: Clear, set and invert never assert `z_we`.
- R6: In memory mode `mem_addr` is the base register value plus the zero-extended `mem_ofs`. When `reg_sel` is 12 (status register), the base is taken as zero.
- R7: Memory sequence: `mem_re` is high in the cycle after acceptance. `mem_rdata` is taken in the cycle after `mem_re`. In the following cycle `mem_we` is high with the edited word at the same address, and `done` is high in the cycle after `mem_we`. At most one of `mem_re`, `mem_we` and `done` is high in any cycle.
- R8: In memory mode only bits 0 to 15 exist: bit 4 of the index is ignored, so index 19 edits bit 3.
- R9: A memory inspect reads the word and never writes it. `done` and `z_we` appear in the cycle after the read data arrives.
- R10: While a memory sequence is in progress (`busy` high), `start` is ignored.
- R11: After reset, `busy`, `done`, `wb_we`, `z_we`, `mem_re` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| fam_set | input | 1 | Opcode family: 0 clear family, 1 set family |
| alt | input | 1 | Alternate-operation bit of the extension |
| grp | input | 2 | Which of the four legacy opcodes; high part of the bit index |
| ext_bit | input | 3 | Low part of the bit index |
| mem_mode | input | 1 | 1 selects the memory operand |
| reg_sel | input | 4 | Target register, or base register in memory mode |
| reg_rdata | input | 32 | Value of the selected register |
| mem_ofs | input | 16 | Offset added to the base in memory mode |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | Memory sequence in progress; requests ignored |
| done | output | 1 | Operation complete (one-cycle pulse) |
| wb_we | output | 1 | Register write-back enable |
| wb_sel | output | 4 | Register to write back |
| wb_data | output | 32 | Edited register value |
| z_we | output | 1 | Zero-flag update enable |
| z_val | output | 1 | New zero-flag value |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 16 | Edited memory word |

## Verification
The assertions check the timing skeleton on every cycle. They cover the spacing of `mem_re`, `mem_we` and `done`, the fact that write-back and flag update are never both high, the one-cycle completion of register requests, and that the address holds while requests are refused. Only the bench's scenarios can show the data values. These are which bit changes for a given group and extension field, the zero-flag polarity, the base-plus-offset sum with the status-register base forced to zero, the dropped index bit in memory mode, and the fact that an inspected word is left unchanged and a refused request leaves no trace.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   // Operation code is {alt, fam_set}
   typedef enum logic [1:0] {
      BOP_CLR = 2'b00,
      BOP_SET = 2'b01,
      BOP_TST = 2'b10,
      BOP_TGL = 2'b11
   } bop_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WT,
      ST_WR,
      ST_DN
   } bseq_e;

   function automatic bop_e make_op(input logic alt, input logic fam_set);
      return bop_e'({alt, fam_set});
   endfunction

endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int W     = 32,
   parameter int IDX_W = 5
) (
   input  logic [W-1:0]     operand,
   input  logic [IDX_W-1:0] idx,
   input  bop_e             op,
   output logic [W-1:0]     result,
   output logic             bit_clear
);

   if (W != (1 << IDX_W)) begin : g_bad_width
      $error("bitop_alu: W must equal 2**IDX_W");
   end

   logic [W-1:0] hit;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign hit[i] = (idx == IDX_W'(i));
      always_comb begin
         unique case (op)
            BOP_CLR: result[i] = operand[i] & ~hit[i];
            BOP_SET: result[i] = operand[i] |  hit[i];
            BOP_TGL: result[i] = operand[i] ^  hit[i];
            default: result[i] = operand[i];
         endcase
      end
   end

   assign bit_clear = ~|(operand & hit);

endmodule

// File: rtl/bitop_mem_seq.sv
module bitop_mem_seq
   import bitop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mem_mode,
   input  logic test_q,
   output logic busy,
   output logic accept,
   output logic rd_cap,
   output logic mem_re,
   output logic mem_we,
   output logic done
);

   bseq_e state, state_n;

   assign busy   = (state == ST_RD) || (state == ST_WT) || (state == ST_WR);
   assign accept = start && !busy;
   assign rd_cap = (state == ST_WT);
   assign mem_re = (state == ST_RD);
   assign mem_we = (state == ST_WR);
   assign done   = (state == ST_DN);

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE, ST_DN: state_n = accept ? (mem_mode ? ST_RD : ST_DN) : ST_IDLE;
         ST_RD:          state_n = ST_WT;
         ST_WT:          state_n = test_q ? ST_DN : ST_WR;
         ST_WR:          state_n = ST_DN;
         default:        state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_n;
   end

   // R7
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_re, mem_we, done}));

   // R7
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> done);

   // R7
   read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_re, 2));

   // R7
   read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (!mem_re && !mem_we && !done));

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int  DATA_W       = 32,
   parameter int  MEM_W        = 16,
   parameter int  NREG         = 16,
   parameter int  OFS_W        = 16,
   parameter int  GRP_W        = 2,
   parameter int  EXT_W        = 3,
   parameter int  STATUS_REG   = 12,
   parameter bit  ZERO_STATUS  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     fam_set,
   input  logic                     alt,
   input  logic [GRP_W-1:0]         grp,
   input  logic [EXT_W-1:0]         ext_bit,
   input  logic                     mem_mode,
   input  logic [$clog2(NREG)-1:0]  reg_sel,
   input  logic [DATA_W-1:0]        reg_rdata,
   input  logic [OFS_W-1:0]         mem_ofs,
   input  logic [MEM_W-1:0]         mem_rdata,
   output logic                     busy,
   output logic                     done,
   output logic                     wb_we,
   output logic [$clog2(NREG)-1:0]  wb_sel,
   output logic [DATA_W-1:0]        wb_data,
   output logic                     z_we,
   output logic                     z_val,
   output logic                     mem_re,
   output logic                     mem_we,
   output logic [DATA_W-1:0]        mem_addr,
   output logic [MEM_W-1:0]         mem_wdata
);

   localparam int IDX_W  = $clog2(DATA_W);
   localparam int MIDX_W = $clog2(MEM_W);
   localparam int RSEL_W = $clog2(NREG);

   if (GRP_W + EXT_W != IDX_W) begin : g_bad_idx
      $error("bitop_unit: GRP_W + EXT_W must address every bit of DATA_W");
   end
   if (MEM_W > DATA_W || MEM_W != (1 << MIDX_W)) begin : g_bad_mem
      $error("bitop_unit: MEM_W must be a power of two not above DATA_W");
   end
   if (OFS_W > DATA_W) begin : g_bad_ofs
      $error("bitop_unit: OFS_W must not exceed DATA_W");
   end
   if (STATUS_REG >= NREG) begin : g_bad_sr
      $error("bitop_unit: STATUS_REG out of range");
   end

   // ---------------- request decode ----------------
   bop_e               op_in;
   logic [IDX_W-1:0]   idx_in;
   logic [DATA_W-1:0]  base;

   assign op_in  = make_op(alt, fam_set);
   assign idx_in = {grp, ext_bit};

   if (ZERO_STATUS) begin : g_zero_base
      assign base = (reg_sel == RSEL_W'(STATUS_REG)) ? '0 : reg_rdata;
   end else begin : g_plain_base
      assign base = reg_rdata;
   end

   // ---------------- datapath ----------------
   logic [DATA_W-1:0]  reg_res;
   logic               reg_zero;
   logic [MEM_W-1:0]   mem_res;
   logic               mem_zero;

   bop_e               op_q;
   logic               mem_q;
   logic [RSEL_W-1:0]  sel_q;
   logic [MIDX_W-1:0]  midx_q;
   logic [DATA_W-1:0]  addr_q;
   logic [DATA_W-1:0]  res_q;
   logic               zf_q;

   bitop_alu #(.W(DATA_W), .IDX_W(IDX_W)) i_reg_alu (
      .operand   (reg_rdata),
      .idx       (idx_in),
      .op        (op_in),
      .result    (reg_res),
      .bit_clear (reg_zero)
   );

   bitop_alu #(.W(MEM_W), .IDX_W(MIDX_W)) i_mem_alu (
      .operand   (mem_rdata),
      .idx       (midx_q),
      .op        (op_q),
      .result    (mem_res),
      .bit_clear (mem_zero)
   );

   // ---------------- sequencing ----------------
   logic accept, rd_cap, test_q;

   assign test_q = (op_q == BOP_TST);

   bitop_mem_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mem_mode (mem_mode),
      .test_q   (test_q),
      .busy     (busy),
      .accept   (accept),
      .rd_cap   (rd_cap),
      .mem_re   (mem_re),
      .mem_we   (mem_we),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= BOP_CLR;
         mem_q  <= 1'b0;
         sel_q  <= '0;
         midx_q <= '0;
         addr_q <= '0;
         res_q  <= '0;
         zf_q   <= 1'b0;
      end else if (accept) begin
         op_q   <= op_in;
         mem_q  <= mem_mode;
         sel_q  <= reg_sel;
         midx_q <= idx_in[MIDX_W-1:0];
         addr_q <= base + DATA_W'(mem_ofs);
         res_q  <= reg_res;
         zf_q   <= reg_zero;
      end else if (rd_cap) begin
         res_q  <= DATA_W'(mem_res);
         zf_q   <= mem_zero;
      end
   end

   assign wb_we     = done && !mem_q && !test_q;
   assign wb_sel    = sel_q;
   assign wb_data   = res_q;
   assign z_we      = done && test_q;
   assign z_val     = zf_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = res_q[MEM_W-1:0];

   // R4
   test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      z_we |-> (!wb_we && !mem_we));

   // R3
   reg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !mem_mode) |=> (done && !mem_re && !mem_we));

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(mem_addr));

   // R5
   wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> (done && !z_we));

endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, fam_set = 1'b0, alt = 1'b0, mem_mode = 1'b0;
   logic [1:0]  grp = '0;
   logic [2:0]  ext_bit = '0;
   logic [3:0]  reg_sel = '0;
   logic [31:0] reg_rdata = '0;
   logic [15:0] mem_ofs = '0;
   logic [15:0] mem_rdata;
   logic        busy, done, wb_we, z_we, z_val, mem_re, mem_we;
   logic [3:0]  wb_sel;
   logic [31:0] wb_data, mem_addr;
   logic [15:0] mem_wdata;

   int nchk = 0;
   int nerr = 0;

   logic [15:0] mem [0:63];
   logic [15:0] rdq = '0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (mem_re) rdq <= mem[mem_addr[5:0]];
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
   end
   assign mem_rdata = rdq;

   bitop_unit i_bitop_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .fam_set(fam_set), .alt(alt),
      .grp(grp), .ext_bit(ext_bit), .mem_mode(mem_mode), .reg_sel(reg_sel),
      .reg_rdata(reg_rdata), .mem_ofs(mem_ofs), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .wb_we(wb_we), .wb_sel(wb_sel),
      .wb_data(wb_data), .z_we(z_we), .z_val(z_val), .mem_re(mem_re),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // expected edit: op = {alt, fam}
   function automatic logic [31:0] edit(input logic a, input logic f,
                                        input logic [31:0] v, input int b);
      logic [31:0] m = 32'h1 << b;
      case ({a, f})
         2'b00:   return v & ~m;
         2'b01:   return v | m;
         2'b11:   return v ^ m;
         default: return v;
      endcase
   endfunction

   task automatic drive(input logic f, input logic a, input logic [1:0] g,
                        input logic [2:0] e, input logic mm, input logic [3:0] s,
                        input logic [31:0] v, input logic [15:0] o);
      start = 1'b1; fam_set = f; alt = a; grp = g; ext_bit = e;
      mem_mode = mm; reg_sel = s; reg_rdata = v; mem_ofs = o;
   endtask

   task automatic reg_op(input string tag, input logic f, input logic a,
                         input logic [1:0] g, input logic [2:0] e,
                         input logic [3:0] s, input logic [31:0] v);
      int b = {g, e};
      @(negedge clk);
      drive(f, a, g, e, 1'b0, s, v, 16'h0);
      @(negedge clk);
      start = 1'b0;
      chk({tag, " done"}, done, 1);
      if (a && !f) begin
         chk({tag, " R4 no wb"}, wb_we, 0);
         chk({tag, " R4 z_we"}, z_we, 1);
         chk({tag, " R4 z_val"}, z_val, ((v >> b) & 1) == 0);
      end else begin
         chk({tag, " R5 no z_we"}, z_we, 0);
         chk({tag, " wb_we"}, wb_we, 1);
         chk({tag, " R1 wb_sel"}, wb_sel, s);
         chk({tag, " R2 wb_data"}, wb_data, edit(a, f, v, b));
      end
      @(negedge clk);
      chk({tag, " done drops"}, done, 0);
   endtask

   task automatic mem_op(input string tag, input logic f, input logic a,
                         input logic [1:0] g, input logic [2:0] e,
                         input logic [3:0] s, input logic [31:0] v,
                         input logic [15:0] o, input logic inject);
      logic [31:0] ea;
      logic [15:0] old, ew;
      logic        tst = a && !f;
      int          b = {g, e} % 16;
      ea  = (s == 4'd12) ? {16'h0, o} : v + {16'h0, o};
      old = mem[ea[5:0]];
      ew  = edit(a, f, {16'h0, old}, b);
      @(negedge clk);
      drive(f, a, g, e, 1'b1, s, v, o);
      @(negedge clk);                                  // read cycle
      start = 1'b0;
      chk({tag, " R7 mem_re"}, mem_re, 1);
      chk({tag, " R6 addr"}, mem_addr, ea);
      @(negedge clk);                                  // wait cycle
      chk({tag, " R7 idle strobes"}, {mem_re, mem_we, done}, 0);
      if (inject) drive(1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 4'd2, 32'h0, 16'h3);
      @(negedge clk);
      if (tst) begin
         chk({tag, " R9 done"}, done, 1);
         chk({tag, " R9 no write"}, mem_we, 0);
         chk({tag, " R9 z_val"}, z_val, ((old >> b) & 1) == 0);
         chk({tag, " R4 z_we"}, z_we, 1);
         @(negedge clk);
         chk({tag, " R9 word kept"}, mem[ea[5:0]], old);
      end else begin
         chk({tag, " R7 mem_we"}, mem_we, 1);
         chk({tag, " R7 write addr"}, mem_addr, ea);
         chk({tag, " R8 wdata"}, mem_wdata, ew);
         @(negedge clk);
         start = 1'b0;
         chk({tag, " R7 done"}, done, 1);
         chk({tag, " R5 no wb/z"}, {wb_we, z_we}, 0);
         chk({tag, " R7 stored"}, mem[ea[5:0]], ew);
      end
      @(negedge clk);
      chk({tag, " R10 no extra op"}, {done, wb_we, mem_re}, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R11 reset strobes", {busy, done, wb_we, z_we, mem_re, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", {busy, done, wb_we, z_we, mem_re, mem_we}, 0);
   endtask

   task automatic t_register_ops;
      reg_op("R1 clear", 1'b0, 1'b0, 2'd2, 3'd5, 4'd3, 32'hFFFF_FFFF);
      reg_op("R1 set", 1'b1, 1'b0, 2'd3, 3'd7, 4'd9, 32'h0);
      reg_op("R1 toggle", 1'b1, 1'b1, 2'd0, 3'd4, 4'd14, 32'h0000_00F0);
      reg_op("R2 set low", 1'b1, 1'b0, 2'd0, 3'd0, 4'd12, 32'h8000_0000);
      reg_op("R4 test zero", 1'b0, 1'b1, 2'd1, 3'd6, 4'd0, 32'hFFFF_BFFF);
      reg_op("R4 test one", 1'b0, 1'b1, 2'd1, 3'd6, 4'd0, 32'h0000_4000);
   endtask

   task automatic t_back_to_back;   // R3
      @(negedge clk);
      drive(1'b1, 1'b0, 2'd1, 3'd1, 1'b0, 4'd5, 32'h0, 16'h0);
      @(negedge clk);
      chk("R3 first done", done, 1);
      chk("R3 first data", wb_data, 32'h0000_0200);
      drive(1'b0, 1'b0, 2'd3, 3'd0, 1'b0, 4'd6, 32'hFFFF_FFFF, 16'h0);
      @(negedge clk);
      start = 1'b0;
      chk("R3 second done", done, 1);
      chk("R3 second sel", wb_sel, 4'd6);
      chk("R3 second data", wb_data, 32'hFEFF_FFFF);
      @(negedge clk);
      chk("R3 done drops", done, 0);
   endtask

   task automatic t_memory_ops;
      for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0101 + 16'h5A00);
      mem[6'h15] = 16'hFFFF;
      mem[6'h21] = 16'h0000;
      mem[6'h30] = 16'h0010;
      mem_op("R6 clear", 1'b0, 1'b0, 2'd1, 3'd2, 4'd3, 32'h0000_0010, 16'h5, 1'b0);
      mem_op("R8 status base", 1'b1, 1'b0, 2'd2, 3'd3, 4'd12, 32'h1234_0000, 16'h21, 1'b0);
      mem_op("R9 test one", 1'b0, 1'b1, 2'd0, 3'd4, 4'd8, 32'h0000_0030, 16'h0, 1'b0);
      mem_op("R9 test zero", 1'b0, 1'b1, 2'd3, 3'd5, 4'd8, 32'h0000_0030, 16'h0, 1'b0);
      mem_op("R1 mem toggle", 1'b1, 1'b1, 2'd1, 3'd7, 4'd15, 32'h0000_0008, 16'h2, 1'b0);
      mem_op("R10 refused", 1'b1, 1'b0, 2'd0, 3'd2, 4'd4, 32'h0000_0020, 16'h1, 1'b1);
   endtask

   initial begin
      #(8 * 200000);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_register_ops();
      t_back_to_back();
      t_memory_ops();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule